// File: doc/BRIEF.md
# Sequence waveform playback controller

The controller turns a list of sequence instructions into one continuous sample stream. Each instruction names a waveform segment by start address and length in samples, and says how often to play it. Instructions and samples share one memory read port, which is taken to have a fixed but unknown latency. Requests carry a kind bit that the memory returns with the matching response. The controller fetches one instruction, plays its segment the required number of times, then moves to the next instruction at the following address. It stops after the instruction marked as the last one, or wraps back to the first instruction when looping is enabled.

To avoid a gap between segments, the next instruction is requested early, while `LEAD` samples of the final pass are still to be requested. If the memory answers within `LEAD-1` cycles, the new segment starts on the cycle after the old one's last request. A late answer is recorded as an underrun, and playback then waits. A segment shorter than `MIN_LEN` samples could not hide the fetch, so it is refused with an error and playback stops. Returned samples pass through a small buffer to a valid/ready output. The number of requests in flight is limited so the buffer never overflows.

The controller has four states:
- `ST_IDLE`: not playing. `start` moves to `ST_FIRST`.
- `ST_FIRST`: the first instruction has been requested. A valid instruction moves to `ST_PLAY`; a short one moves to `ST_IDLE`.
- `ST_PLAY`: segment samples are being requested. At the end of a segment:
  - the last instruction, with looping disabled, moves to `ST_IDLE`;
  - a next instruction that has not yet arrived moves to `ST_GAP` and raises the underrun flag;
  - a short next instruction moves to `ST_IDLE`;
  - a valid next instruction stays in `ST_PLAY`.
- `ST_GAP`: waiting for a late instruction. It then moves to `ST_PLAY`, or to `ST_IDLE` if the instruction is short.

Top module: `seq_player`

## Requirements
- R1: After reset `out_valid`, `busy`, `underrun`, `seg_error` and `mem_req` are all 0.
- R2: Instruction k is read from address `seq_base + k`. Its word holds the start address in bits [31:0], the length in [55:32], the repeat field in [71:56] and the last-instruction flag in bit 72. The output is the samples at `start .. start+len-1` of each segment, in instruction order.
- R3: A repeat field of N plays the segment N+1 times back to back.
- R4: The next instruction is requested when `LEAD` samples of the final pass remain to be requested. With memory latency of at most `LEAD-1` cycles and a consumer that is always ready, no underrun occurs. Exactly one instruction request is made per instruction played, and none after the last instruction when looping is off.
- R5: With `loop_en` = 1, the instruction with the last flag is followed by instruction 0, and playback continues with `busy` held at 1.
- R6: If a segment ends before the next instruction has arrived, `underrun` is set and stays set until the next `start`. Playback resumes when the instruction arrives, with no sample lost or reordered.
- R7: While `out_valid` is 0, `out_data` keeps the value of the last accepted sample.
- R8: An instruction with length below `MIN_LEN` is not played. It sets `seg_error`, stops playback (`busy` = 0) and is cleared by the next `start`. A length of exactly `MIN_LEN` is accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged. Under any `out_ready` pattern every sample is delivered once.
- R10: `mem_instr` is 1 exactly on instruction requests. A sample is taken from bits [15:0] of the returned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback from instruction 0 (accepted when idle) |
| loop_en | input | 1 | Wrap to instruction 0 after the last instruction |
| seq_base | input | 32 | Address of instruction 0 |
| mem_req | output | 1 | Read request to the shared memory |
| mem_instr | output | 1 | Request kind: 1 instruction, 0 sample |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Response valid |
| mem_rinstr | input | 1 | Kind echoed with the response |
| mem_rdata | input | MEM_W | Response word |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | SAMP_W | Output sample |
| busy | output | 1 | Controller not idle |
| underrun | output | 1 | Latched late-instruction flag |
| seg_error | output | 1 | Latched short-segment flag |

## Verification
Two events can fall in the same cycle. At the end of a segment, the last sample request and the hand-over to the prefetched instruction can coincide. A prefetch response can also arrive in the very cycle a segment ends, rather than one cycle earlier.

The bench provokes the first case by answering at latency `LEAD-1`, which makes the instruction arrive exactly in time. It provokes the second case by delaying only instruction answers, which pushes the segment end ahead of the instruction. Each case is judged from the port behaviour. The output stream must equal the concatenated segments sample for sample. `underrun` must stay 0 in the first case and become 1 in the second. `out_data` must hold its value across every gap this produces.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int REP_W  = 16;

    // Packed from MSB: last flag, repeat, length, start address
    typedef struct packed {
        logic              last;
        logic [REP_W-1:0]  rep;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] start;
    } seq_instr_t;

    localparam int INSTR_W = $bits(seq_instr_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_PLAY,
        ST_GAP
    } seq_state_t;

endpackage

// File: rtl/seq_fifo.sv
module seq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic [AW:0]   count
);

    logic [W-1:0]  store_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                store_q[wr_q] <= push_data;
                wr_q          <= bump(wr_q);
            end
            if (pop)
                rd_q <= bump(rd_q);
            count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
        end
    end

    assign head  = store_q[rd_q];
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < (AW+1)'(DEPTH))); // R9

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int LEAD    = 5,
    parameter int MIN_LEN = 8,
    parameter int MEM_W   = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loop_en,
    input  logic [ADDR_W-1:0] seq_base,
    input  logic              credit_ok,
    input  logic              rvalid,
    input  logic              rinstr,
    input  logic [MEM_W-1:0]  rdata,
    output logic              req,
    output logic              req_instr,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              underrun,
    output logic              seg_error
);

    seq_state_t        state_q, state_d;
    seq_instr_t        cur_q, pend_q;
    logic              pend_v_q, pref_done_q;
    logic [LEN_W-1:0]  off_q;
    logic [REP_W-1:0]  passes_q;
    logic [ADDR_W-1:0] fetch_idx_q;

    logic             has_next, last_pass, want_pref, issue_samp, seg_end;
    logic             take, load, reject, pend_bad, kick;
    logic [LEN_W-1:0] remain;

    always_comb begin
        kick       = (state_q == ST_IDLE) && start;
        has_next   = !(cur_q.last && !loop_en);
        last_pass  = (passes_q == '0);
        remain     = cur_q.len - off_q;
        want_pref  = (state_q == ST_PLAY) && last_pass && !pref_done_q
                     && has_next && (remain == LEN_W'(LEAD));
        issue_samp = (state_q == ST_PLAY) && !want_pref && credit_ok;
        seg_end    = issue_samp && last_pass && (off_q == cur_q.len - LEN_W'(1));
        pend_bad   = (pend_q.len < LEN_W'(MIN_LEN));
        take       = pend_v_q && ((state_q == ST_FIRST) || (state_q == ST_GAP)
                                  || (seg_end && has_next));
        load       = take && !pend_bad;
        reject     = take && pend_bad;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_FIRST;
            ST_FIRST: if (pend_v_q) state_d = pend_bad ? ST_IDLE : ST_PLAY;
            ST_PLAY: begin
                if (seg_end) begin
                    if (!has_next)     state_d = ST_IDLE;
                    else if (!pend_v_q) state_d = ST_GAP;
                    else if (pend_bad)  state_d = ST_IDLE;
                    else                state_d = ST_PLAY;
                end
            end
            ST_GAP:   if (pend_v_q) state_d = pend_bad ? ST_IDLE : ST_PLAY;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        req       = kick || want_pref || issue_samp;
        req_instr = kick || want_pref;
        busy      = (state_q != ST_IDLE);
        if (kick)           addr = seq_base;
        else if (want_pref) addr = seq_base + fetch_idx_q;
        else                addr = cur_q.start + ADDR_W'(off_q);
    end

    // Segment counters, pending instruction and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            pend_q      <= '0;
            pend_v_q    <= 1'b0;
            pref_done_q <= 1'b0;
            off_q       <= '0;
            passes_q    <= '0;
            fetch_idx_q <= '0;
            underrun    <= 1'b0;
            seg_error   <= 1'b0;
        end else begin
            if (rvalid && rinstr) begin
                pend_v_q <= 1'b1;
                pend_q   <= seq_instr_t'(rdata[INSTR_W-1:0]);
            end
            if (kick) begin
                underrun    <= 1'b0;
                seg_error   <= 1'b0;
                fetch_idx_q <= '0;
                pend_v_q    <= 1'b0;
            end
            if (want_pref)
                pref_done_q <= 1'b1;
            if (issue_samp) begin
                if (off_q == cur_q.len - LEN_W'(1)) begin
                    off_q <= '0;
                    if (!last_pass) passes_q <= passes_q - 1'b1;
                end else begin
                    off_q <= off_q + 1'b1;
                end
            end
            if (state_q == ST_PLAY && seg_end && !has_next)
                pend_v_q <= 1'b0;
            if (state_q == ST_PLAY && seg_end && has_next && !pend_v_q)
                underrun <= 1'b1;
            if (load) begin
                cur_q       <= pend_q;
                off_q       <= '0;
                passes_q    <= pend_q.rep;
                pref_done_q <= 1'b0;
                pend_v_q    <= 1'b0;
                fetch_idx_q <= pend_q.last ? '0 : fetch_idx_q + 1'b1;
            end
            if (reject) begin
                pend_v_q  <= 1'b0;
                seg_error <= 1'b1;
            end
        end
    end

    AST_ONE_INSTR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_instr && !kick) |-> !pend_v_q); // R4

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !kick) |=> underrun); // R6

    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seg_error) |-> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/seq_player.sv
module seq_player
    import seq_pkg::*;
#(
    parameter int MEM_W      = 80,
    parameter int SAMP_W     = 16,
    parameter int LEAD       = 5,
    parameter int MIN_LEN    = 8,
    parameter int FIFO_DEPTH = 8,
    localparam int FAW       = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
    localparam int CW        = FAW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              loop_en,
    input  logic [31:0]       seq_base,
    output logic              mem_req,
    output logic              mem_instr,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic              mem_rinstr,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SAMP_W-1:0] out_data,
    output logic              busy,
    output logic              underrun,
    output logic              seg_error
);

    logic [FAW:0]       fifo_count;
    logic [CW-1:0]      inflight_q;
    logic               credit_ok, samp_push, samp_req, fifo_empty, pop;
    logic [SAMP_W-1:0]  head, last_q;

    assign samp_req  = mem_req && !mem_instr;
    assign samp_push = mem_rvalid && !mem_rinstr;
    assign credit_ok = (CW'(fifo_count) + inflight_q) < CW'(FIFO_DEPTH);
    assign out_valid = !fifo_empty;
    assign pop       = out_valid && out_ready;
    assign out_data  = fifo_empty ? last_q : head;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
            last_q     <= '0;
        end else begin
            inflight_q <= inflight_q + (samp_req ? 1'b1 : 1'b0)
                                     - (samp_push ? 1'b1 : 1'b0);
            if (pop) last_q <= head;
        end
    end

    seq_ctrl #(
        .LEAD    (LEAD),
        .MIN_LEN (MIN_LEN),
        .MEM_W   (MEM_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .loop_en   (loop_en),
        .seq_base  (seq_base),
        .credit_ok (credit_ok),
        .rvalid    (mem_rvalid),
        .rinstr    (mem_rinstr),
        .rdata     (mem_rdata),
        .req       (mem_req),
        .req_instr (mem_instr),
        .addr      (mem_addr),
        .busy      (busy),
        .underrun  (underrun),
        .seg_error (seg_error)
    );

    seq_fifo #(
        .W     (SAMP_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (samp_push),
        .push_data (mem_rdata[SAMP_W-1:0]),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .count     (fifo_count)
    );

    AST_HOLD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |=> (out_valid || $stable(out_data))); // R7

    AST_HANDSHAKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

endmodule

// File: tb/seq_player_test.sv
module seq_player_test;

    localparam int MEM_W = 80;
    localparam int SW    = 16;
    localparam int LAT   = 4;
    localparam logic [31:0] IBASE = 32'h0010_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic loop_en = 1'b0;
    logic mem_req, mem_instr;
    logic [31:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic mem_rinstr = 1'b0;
    logic [MEM_W-1:0] mem_rdata = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [SW-1:0] out_data;
    logic busy, underrun, seg_error;

    always #2 clk = ~clk;

    seq_player #(.MEM_W(MEM_W), .SAMP_W(SW), .LEAD(5), .MIN_LEN(8), .FIFO_DEPTH(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en), .seq_base(IBASE),
        .mem_req(mem_req), .mem_instr(mem_instr), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rinstr(mem_rinstr), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy), .underrun(underrun), .seg_error(seg_error));

    int n_cmp = 0;
    int n_bad = 0;
    int ireq_cnt = 0;
    int extra_instr = 0;
    bit mon_en = 0;
    bit allow_extra = 0;
    bit ready_rand = 0;
    bit have_last = 0;
    bit prev_stall = 0;
    logic [SW-1:0] last_acc, prev_data;
    logic [15:0] lfsr = 16'hACE1;
    logic [72:0] itab [16];
    logic [SW-1:0] exp_q [$];
    longint due_q [$];
    bit kind_q [$];
    logic [MEM_W-1:0] data_q [$];
    longint ecnt = 0;
    longint last_due = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [SW-1:0] samp(input logic [31:0] a);
        return a[15:0] ^ {a[23:16], a[31:24]} ^ 16'h3C5A;
    endfunction

    function automatic logic [MEM_W-1:0] mem_word(input logic [31:0] a);
        if (a >= IBASE && a < IBASE + 32'd16) return MEM_W'(itab[a - IBASE]);
        return MEM_W'(samp(a));
    endfunction

    // Behavioural in-order memory with fixed latency, extra delay on instructions
    always @(posedge clk) begin
        ecnt++;
        if (!rst_n) begin
            due_q.delete(); kind_q.delete(); data_q.delete();
            last_due = 0;
            mem_rvalid <= 1'b0;
        end else begin
            if (mem_req) begin
                longint d;
                d = ecnt + LAT - 1 + (mem_instr ? extra_instr : 0);
                if (d <= last_due) d = last_due + 1;
                last_due = d;
                due_q.push_back(d);
                kind_q.push_back(mem_instr);
                data_q.push_back(mem_word(mem_addr));
            end
            if (due_q.size() > 0 && due_q[0] <= ecnt) begin
                mem_rvalid <= 1'b1;
                mem_rinstr <= kind_q[0];
                mem_rdata  <= data_q[0];
                void'(due_q.pop_front()); void'(kind_q.pop_front()); void'(data_q.pop_front());
            end else begin
                mem_rvalid <= 1'b0;
            end
        end
    end

    // Per-clock comparison against the reference stream
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = ready_rand ? (lfsr[0] | lfsr[4]) : 1'b1;
        if (rst_n && mon_en) begin
            if (prev_stall) begin
                chk(out_valid == 1'b1, "R9 valid held", out_valid, 1);
                chk(out_data == prev_data, "R9 data held", out_data, prev_data);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    if (!allow_extra) chk(1'b0, "R2 unexpected sample", out_data, 0);
                end else begin
                    chk(out_data == exp_q[0], "R2/R3 stream sample", out_data, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                last_acc = out_data;
                have_last = 1;
            end else if (!out_valid && have_last) begin
                chk(out_data == last_acc, "R7 hold last sample", out_data, last_acc);
            end
            if (mem_req) begin
                chk(mem_instr == (mem_addr >= IBASE && mem_addr < IBASE + 32'd16),
                    "R10 request kind", mem_instr, !mem_instr);
                if (mem_instr) ireq_cnt++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic add_instr(input int idx, input logic [31:0] st, input int len,
                             input int rep, input bit last, input bit play);
        itab[idx] = {last, 16'(rep), 24'(len), st};
        if (play)
            for (int p = 0; p <= rep; p++)
                for (int i = 0; i < len; i++)
                    exp_q.push_back(samp(st + 32'(i)));
    endtask

    task automatic do_reset();
        mon_en = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        have_last = 0;
        prev_stall = 0;
        exp_q.delete();
        @(negedge clk);
    endtask

    task automatic run(input string tag, input bit lp);
        loop_en = lp;
        ireq_cnt = 0;
        mon_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !busy && !out_valid && due_q.size() == 0) break;
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) itab[i] = '0;
        do_reset();
        // R1: reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(underrun == 0, "R1 underrun", underrun, 0);
        chk(seg_error == 0, "R1 seg_error", seg_error, 0);
        chk(mem_req == 0, "R1 mem_req", mem_req, 0);

        // R2/R4: three segments, minimum length accepted, prefetch in time
        add_instr(0, 32'h0000_0100, 8, 0, 0, 1);
        add_instr(1, 32'h0000_2000, 12, 0, 0, 1);
        add_instr(2, 32'h0003_0000, 9, 0, 1, 1);
        run("R2 sequence drained", 0);
        chk(underrun == 0, "R4 no underrun at latency LEAD-1", underrun, 0);
        chk(seg_error == 0, "R8 length MIN_LEN accepted", seg_error, 0);
        chk(ireq_cnt == 3, "R4 one fetch per instruction", ireq_cnt, 3);
        chk(busy == 0, "R2 stops after last", busy, 0);

        // R3: repeat counts
        add_instr(0, 32'h0000_0500, 10, 2, 0, 1);
        add_instr(1, 32'h0000_0800, 8, 1, 1, 1);
        run("R3 repeats drained", 0);
        chk(underrun == 0, "R3 no underrun", underrun, 0);

        // R9: same sequence under random backpressure
        ready_rand = 1;
        add_instr(0, 32'h0000_0500, 10, 2, 0, 1);
        add_instr(1, 32'h0000_0800, 8, 1, 1, 1);
        run("R9 backpressure drained", 0);
        ready_rand = 0;

        // R5: loop mode, three passes checked
        add_instr(0, 32'h0000_0040, 8, 0, 0, 0);
        add_instr(1, 32'h0000_0090, 9, 1, 1, 0);
        for (int k = 0; k < 3; k++) begin
            add_instr(0, 32'h0000_0040, 8, 0, 0, 1);
            add_instr(1, 32'h0000_0090, 9, 1, 1, 1);
        end
        allow_extra = 1;
        loop_en = 1'b1;
        mon_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0) break;
        end
        chk(exp_q.size() == 0, "R5 looped stream", exp_q.size(), 0);
        chk(busy == 1, "R5 still playing", busy, 1);
        chk(underrun == 0, "R5 no underrun", underrun, 0);
        allow_extra = 0;
        loop_en = 1'b0;
        do_reset();

        // R6: late instructions cause latched underrun, stream intact
        extra_instr = 4;
        add_instr(0, 32'h0000_0100, 8, 0, 0, 1);
        add_instr(1, 32'h0000_2000, 12, 0, 0, 1);
        add_instr(2, 32'h0003_0000, 9, 0, 1, 1);
        run("R6 late stream drained", 0);
        chk(underrun == 1, "R6 underrun latched", underrun, 1);
        chk(busy == 0, "R6 completes", busy, 0);
        extra_instr = 0;
        add_instr(0, 32'h0000_0100, 8, 0, 0, 1);
        add_instr(1, 32'h0000_2000, 12, 0, 0, 1);
        add_instr(2, 32'h0003_0000, 9, 0, 1, 1);
        run("R6 rerun drained", 0);
        chk(underrun == 0, "R6 cleared by start", underrun, 0);

        // R8: short segment rejected
        add_instr(0, 32'h0000_0100, 8, 0, 0, 1);
        add_instr(1, 32'h0000_0200, 7, 0, 0, 0);
        add_instr(2, 32'h0000_0300, 8, 0, 1, 0);
        run("R8 only first segment", 0);
        chk(seg_error == 1, "R8 error raised", seg_error, 1);
        chk(busy == 0, "R8 stopped", busy, 0);
        chk(ireq_cnt == 2, "R8 no fetch after reject", ireq_cnt, 2);
        add_instr(1, 32'h0000_0200, 8, 0, 1, 0);
        add_instr(0, 32'h0000_0100, 8, 0, 0, 1);
        add_instr(1, 32'h0000_0200, 8, 0, 1, 1);
        run("R8 restart drained", 0);
        chk(seg_error == 0, "R8 cleared by start", seg_error, 0);

        mon_en = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule